// File: doc/BRIEF.md
# Butterfly Destination-Tag Router

This block is a pipelined butterfly switching fabric joining N source ports to N destination ports, where N is a power of two (8 by default). The fabric has log2(N)+1 ranks of switch points; the first rank is the set of input columns, the last rank is the set of output columns, and one register stage sits between each pair of neighbouring ranks. A packet enters on any source column together with a destination index and a payload, and the fabric steers it to the matching output column with no central routing table.

Steering is self-directed. At each rank the switch looks at the leading bit of the remaining tag, compares it with the same-weight bit of its own column index, and either passes the packet straight down (bits equal) or over the cross link to the column whose index differs in exactly that bit (bits differ). The leading bit is then removed and the shortened tag moves on. Ranks consume destination bits from most significant to least significant, so after the final rank every column bit equals the destination.

When a straight packet and a cross packet want the same next-rank slot in one cycle, the straight packet wins and the other one waits in place. At the inputs this appears as a per-source blocked flag; the source must keep its request steady until the flag drops. Inner ranks hold losing packets in their registers, and a slot is reused in the same cycle as its current occupant moves on.

Top module: `bfly_router`

## Requirements
- R1: While reset is held and no request is offered, out_valid_o is all zero and in_blocked_o is all zero.
- R2: A packet offered at any source s with destination d leaves only on output column d (out_valid_o equals a one-hot vector with bit d set) and its payload is unchanged, for every pair (s, d).
- R3: An uncontended packet is taken at the rising edge at which it is offered with in_blocked_o low; it appears on the outputs after exactly log2(N) rising edges counting that edge, and stays there for one cycle.
- R4: At rank r (r = 0 is the input rank) the steering bit is destination bit log2(N)-1-r; if it equals the same bit of the current column the packet goes straight, otherwise it crosses to the column with that bit inverted. With all N sources active and destination equal to source (all straight) or to source XOR (N-1) (all cross), no source is blocked and all N packets arrive in the same cycle.
- R5: If in one cycle a straight request and a cross request target the same slot, the straight request proceeds and the cross requester sees in_blocked_o set in that same cycle.
- R6: in_blocked_o is only set for a source whose in_valid_i is set; a blocked packet is not taken, and once the blocking clears the held packet is delivered exactly once. The fabric never emits more packets than it has accepted.
- R7: A single source may offer a new uncontended packet every cycle; none is blocked and they leave on consecutive cycles in the order offered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | N_NODES | Request per source column |
| in_dest_i | input | N_NODES*log2(N_NODES) | Destination index per source, source s in bits [s*AW +: AW] |
| in_data_i | input | N_NODES*DATA_W | Payload per source, source s in bits [s*DATA_W +: DATA_W] |
| in_blocked_o | output | N_NODES | Source request lost arbitration this cycle and must be held |
| out_valid_o | output | N_NODES | A packet is present on this output column |
| out_data_o | output | N_NODES*DATA_W | Payload per output column, column d in bits [d*DATA_W +: DATA_W] |

## Verification
A wrong steering decision at any rank moves a packet to a column whose index differs in that rank's bit, so it shows as a wrong one-hot out_valid_o pattern exactly log2(N) edges after entry, and the full sweep of source and destination pairs touches every switch in both directions. A wrong priority choice shows in in_blocked_o in the same cycle as the conflicting requests, before any edge. A held packet that is dropped or duplicated shows one edge after its expected exit as a missing or repeated output, and a missing or extra register stage shifts the exit edge of every packet.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  // column bit examined by a given rank, leading bit first
  function automatic int steer_bit(input int rank, input int aw);
    return aw - 1 - rank;
  endfunction
endpackage

// File: rtl/bfly_switch.sv
module bfly_switch (
  input  logic straight_req_i,
  input  logic cross_req_i,
  input  logic slot_free_i,
  output logic straight_gnt_o,
  output logic cross_gnt_o
);
  assign straight_gnt_o = slot_free_i & straight_req_i;
  assign cross_gnt_o    = slot_free_i & cross_req_i & ~straight_req_i;
endmodule

// File: rtl/bfly_rank.sv
module bfly_rank
  import bfly_pkg::*;
#(
  parameter int N_NODES = 8,
  parameter int AW      = 3,
  parameter int DW      = 8,
  parameter int RANK    = 0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_NODES-1:0]           up_valid_i,
  input  logic [N_NODES-1:0][AW-1:0]   up_tag_i,
  input  logic [N_NODES-1:0][DW-1:0]   up_data_i,
  input  logic [N_NODES-1:0]           down_move_i,
  output logic [N_NODES-1:0]           up_move_o,
  output logic [N_NODES-1:0]           q_valid_o,
  output logic [N_NODES-1:0][AW-1:0]   q_tag_o,
  output logic [N_NODES-1:0][DW-1:0]   q_data_o
);
  localparam int SBIT = steer_bit(RANK, AW);
  localparam int MASK = 1 << SBIT;

  logic [N_NODES-1:0] want_x, s_req, x_req, gnt_s, gnt_x, slot_free;

  // slot reusable when empty or its occupant advances this cycle
  assign slot_free = ~q_valid_o | down_move_i;

  for (genvar c = 0; c < N_NODES; c++) begin : g_col
    localparam int   PART    = c ^ MASK;
    localparam logic COL_BIT = ((c >> SBIT) & 1) != 0;

    logic          v_q;
    logic [AW-1:0] t_q;
    logic [DW-1:0] d_q;

    assign want_x[c] = up_tag_i[c][AW-1] ^ COL_BIT;
    assign s_req[c]  = up_valid_i[c] & ~want_x[c];
    assign x_req[c]  = up_valid_i[c] &  want_x[c];

    bfly_switch u_sw (
      .straight_req_i (s_req[c]),
      .cross_req_i    (x_req[PART]),
      .slot_free_i    (slot_free[c]),
      .straight_gnt_o (gnt_s[c]),
      .cross_gnt_o    (gnt_x[c])
    );

    assign up_move_o[c] = gnt_s[c] | (x_req[c] & gnt_x[PART]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        t_q <= '0;
        d_q <= '0;
      end else if (slot_free[c]) begin
        v_q <= gnt_s[c] | gnt_x[c];
        if (gnt_s[c]) begin
          t_q <= up_tag_i[c] << 1;
          d_q <= up_data_i[c];
        end else if (gnt_x[c]) begin
          t_q <= up_tag_i[PART] << 1;
          d_q <= up_data_i[PART];
        end
      end
    end

    assign q_valid_o[c] = v_q;
    assign q_tag_o[c]   = t_q;
    assign q_data_o[c]  = d_q;
  end
endmodule

// File: rtl/bfly_router.sv
module bfly_router #(
  parameter int N_NODES = 8,
  parameter int DATA_W  = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_NODES-1:0]            in_valid_i,
  input  logic [N_NODES*$clog2(N_NODES)-1:0] in_dest_i,
  input  logic [N_NODES*DATA_W-1:0]     in_data_i,
  output logic [N_NODES-1:0]            in_blocked_o,
  output logic [N_NODES-1:0]            out_valid_o,
  output logic [N_NODES*DATA_W-1:0]     out_data_o
);
  localparam int AW = $clog2(N_NODES);

  for (genvar r = 0; r < AW; r++) begin : g_rank
    logic [N_NODES-1:0]             up_v, up_mv, dn_mv, q_v;
    logic [N_NODES-1:0][AW-1:0]     up_t, q_t;
    logic [N_NODES-1:0][DATA_W-1:0] up_d, q_d;

    if (r == 0) begin : g_head
      assign up_v = in_valid_i;
      assign up_t = in_dest_i;
      assign up_d = in_data_i;
    end else begin : g_mid
      assign up_v = g_rank[r-1].q_v;
      assign up_t = g_rank[r-1].q_t;
      assign up_d = g_rank[r-1].q_d;
    end

    if (r == AW-1) begin : g_tail
      // output rank always drains
      logic [N_NODES-1:0][AW-1:0] tag_unused;
      assign dn_mv      = '1;
      assign tag_unused = q_t;
    end else begin : g_link
      assign dn_mv = g_rank[r+1].up_mv;
    end

    bfly_rank #(
      .N_NODES (N_NODES),
      .AW      (AW),
      .DW      (DATA_W),
      .RANK    (r)
    ) u_rank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .up_valid_i  (up_v),
      .up_tag_i    (up_t),
      .up_data_i   (up_d),
      .down_move_i (dn_mv),
      .up_move_o   (up_mv),
      .q_valid_o   (q_v),
      .q_tag_o     (q_t),
      .q_data_o    (q_d)
    );
  end

  assign in_blocked_o = in_valid_i & ~g_rank[0].up_mv;
  assign out_valid_o  = g_rank[AW-1].q_v;
  assign out_data_o   = g_rank[AW-1].q_d;
endmodule

// File: rtl/bfly_router_chk.sv
module bfly_router_chk #(
  parameter int N_NODES = 8,
  parameter int AW      = 3
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_NODES-1:0]     in_valid_i,
  input logic [N_NODES*AW-1:0]  in_dest_i,
  input logic [N_NODES-1:0]     in_blocked_o,
  input logic [N_NODES-1:0]     out_valid_o
);
  localparam int MSB_MASK = 1 << (AW - 1);

  logic [N_NODES*AW-1:0] dest_unused;
  logic [31:0] acc_q, emit_q;

  assign dest_unused = in_dest_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      emit_q <= '0;
    end else begin
      acc_q  <= acc_q  + 32'($countones(in_valid_i & ~in_blocked_o));
      emit_q <= emit_q + 32'($countones(out_valid_o));
    end
  end

  // R6: blocking only ever applies to a live request
  p_blocked_has_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_blocked_o & ~in_valid_i) == '0);

  // R6: nothing leaves that was not taken
  p_no_spurious_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_q <= acc_q);

  // R3: in-flight packets never exceed the register slots
  p_inflight_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q - emit_q) <= 32'(N_NODES * AW));

  for (genvar c = 0; c < N_NODES; c++) begin : g_prio
    localparam int   PART = c ^ MSB_MASK;
    localparam logic CB   = ((c >> (AW - 1)) & 1) != 0;
    // R5: straight request into slot c beats the cross request from the partner
    p_straight_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i[c] && in_dest_i[c*AW + AW-1] == CB &&
       in_valid_i[PART] && in_dest_i[PART*AW + AW-1] == CB)
      |-> in_blocked_o[PART]);
  end
endmodule

bind bfly_router bfly_router_chk #(
  .N_NODES (N_NODES),
  .AW      (AW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_dest_i    (in_dest_i),
  .in_blocked_o (in_blocked_o),
  .out_valid_o  (out_valid_o)
);

// File: tb/tb_bfly_router.sv
module tb_bfly_router;
  localparam int N  = 8;
  localparam int AW = 3;
  localparam int DW = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0]    in_valid;
  logic [N*AW-1:0] in_dest;
  logic [N*DW-1:0] in_data;
  logic [N-1:0]    blk, out_v;
  logic [N*DW-1:0] out_d;
  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  bfly_router #(.N_NODES(N), .DATA_W(DW)) dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (in_valid),
    .in_dest_i    (in_dest),
    .in_data_i    (in_data),
    .in_blocked_o (blk),
    .out_valid_o  (out_v),
    .out_data_o   (out_d)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    in_valid = '0;
    in_dest  = '0;
    in_data  = '0;
  endtask

  task automatic put(input int s, input int d, input logic [DW-1:0] pl);
    in_valid[s]          = 1'b1;
    in_dest[s*AW +: AW]  = AW'(d);
    in_data[s*DW +: DW]  = pl;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    clear_in();
    repeat (3) @(negedge clk_i);
    chk(out_v == '0, "R1", "out_valid in reset", 32'(out_v), 0);
    chk(blk == '0, "R1", "blocked in reset", 32'(blk), 0);
    rst_ni = 1'b1;

    // R2 R3: every source/destination pair alone
    for (int s = 0; s < N; s++) begin
      for (int d = 0; d < N; d++) begin
        logic [DW-1:0] pl;
        int lat;
        pl = {4'(s), 4'(d)};
        @(negedge clk_i);
        put(s, d, pl);
        #1 chk(blk == '0, "R3", "lone packet blocked", 32'(blk), 0);
        @(posedge clk_i);
        lat = 1;
        @(negedge clk_i);
        clear_in();
        while (out_v == '0 && lat < 10) begin
          @(posedge clk_i);
          lat++;
          @(negedge clk_i);
        end
        chk(out_v == N'(1 << d), "R2", "exit column", 32'(out_v), 32'(1 << d));
        chk(out_d[d*DW +: DW] == pl, "R2", "payload", 32'(out_d[d*DW +: DW]), 32'(pl));
        chk(lat == AW, "R3", "latency edges", 32'(lat), AW);
        @(posedge clk_i);
        @(negedge clk_i);
        chk(out_v == '0, "R3", "single cycle exit", 32'(out_v), 0);
      end
    end

    // R4: all-cross and all-straight full permutations
    for (int mode = 0; mode < 2; mode++) begin
      int x;
      x = (mode == 0) ? (N - 1) : 0;
      @(negedge clk_i);
      for (int s = 0; s < N; s++) put(s, s ^ x, {4'(s), 4'(s ^ x)});
      #1 chk(blk == '0, "R4", "permutation blocked", 32'(blk), 0);
      @(posedge clk_i);
      @(negedge clk_i);
      clear_in();
      repeat (AW - 1) begin
        @(posedge clk_i);
        @(negedge clk_i);
      end
      chk(out_v == '1, "R4", "permutation exits", 32'(out_v), 32'({N{1'b1}}));
      for (int d = 0; d < N; d++)
        chk(out_d[d*DW +: DW] == {4'(d ^ x), 4'(d)}, "R4", "permutation payload",
            32'(out_d[d*DW +: DW]), 32'({4'(d ^ x), 4'(d)}));
    end

    // R5 R6: src0->0 straight vs src4->1 cross into column 0 at the first rank
    @(negedge clk_i);
    clear_in();
    put(0, 0, 8'hA0);
    put(4, 1, 8'hB4);
    #1 chk(blk == 8'h10, "R5", "cross loser blocked", 32'(blk), 32'h10);
    @(posedge clk_i);
    @(negedge clk_i);
    in_valid[0] = 1'b0;
    #1 chk(blk == '0, "R6", "held packet released", 32'(blk), 0);
    @(posedge clk_i);
    @(negedge clk_i);
    clear_in();
    chk(out_v == '0, "R6", "nothing early", 32'(out_v), 0);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(out_v == 8'h01, "R5", "winner exit", 32'(out_v), 32'h01);
    chk(out_d[0 +: DW] == 8'hA0, "R5", "winner payload", 32'(out_d[0 +: DW]), 32'hA0);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(out_v == 8'h02, "R6", "held packet exit", 32'(out_v), 32'h02);
    chk(out_d[DW +: DW] == 8'hB4, "R6", "held payload", 32'(out_d[DW +: DW]), 32'hB4);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(out_v == '0, "R6", "delivered once", 32'(out_v), 0);

    // R7: back-to-back packets on one source
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      clear_in();
      put(3, 3, 8'h30 + 8'(k));
      #1 chk(blk == '0, "R7", "stream blocked", 32'(blk), 0);
      @(posedge clk_i);
    end
    @(negedge clk_i);
    clear_in();
    for (int k = 0; k < 3; k++) begin
      chk(out_v == 8'h08, "R7", "stream exit", 32'(out_v), 32'h08);
      chk(out_d[3*DW +: DW] == 8'h30 + 8'(k), "R7", "stream order",
          32'(out_d[3*DW +: DW]), 32'(8'h30 + 8'(k)));
      @(posedge clk_i);
      @(negedge clk_i);
    end
    chk(out_v == '0, "R7", "stream drained", 32'(out_v), 0);

    summary();
    $finish;
  end
endmodule